// File: doc/BRIEF.md
# ATA PIO Cycle Timing Engine

This block performs one host-side programmed-I/O register access on an ATA device bus. A request names the direction, which of the two chip-select lines to assert, a 3-bit device register address, 16-bit write data and four 8-bit timing counts. The block then walks a fixed sequence of phases: address setup, strobe, hold and end-of-cycle recovery. It drives the chip selects, the address lines, the read or write strobe and the data-bus driver enable. A read returns its data with a one-clock acknowledge.

Each phase lasts its programmed count plus one clock. The hold window and the recovery window both start when the strobe is released. The cycle ends when the longer of the two has run out, so a full cycle takes (setup+1) + (strobe+1) + max(hold, recovery) + 1 clocks. At a 100 MHz clock the mode-0 counts of 6, 28, 2 and 23 give 70 ns setup, 290 ns strobe, 30 ns hold and 240 ns recovery.

A per-request stretch flag lets the device extend the strobe phase by pulling its ready line low. The ready line is resynchronised through two flops before it is used.

The controller has five states. IDLE moves to SETUP when a request is accepted. SETUP moves to STROBE when its count expires. STROBE stays put while stretched, and otherwise moves to HOLD when its count expires. HOLD moves to IDLE if the recovery count has also run out, and to RECOVER if it has not. RECOVER moves to IDLE when its count expires.

Top module: `pio_cycle_engine`

## Requirements
- R1: After reset the busy flag, acknowledge, driver enable, address lines and read data are all 0. Both chip selects and both strobes are high (inactive).
- R2: A request is taken when req_valid is high while busy is low. Busy is high from the next clock until the end of recovery. A req_valid pulse while busy is high is ignored. While busy is low, every chip select and strobe is inactive.
- R3: For setup+1 clocks (SETUP) the selected chip select is low and the address lines carry the request address, with both strobes high. req_cs1=1 selects dev_cs1_n and req_cs1=0 selects dev_cs0_n. At no time are both chip selects low.
- R4: For strobe+1 clocks (STROBE, when not stretched) dev_rd_n is low for a read (req_write=0) and dev_wr_n is low for a write (req_write=1). The two strobes are never low together.
- R5: After the strobe is released, the chip select and address stay valid for hold+1 clocks (HOLD). For a write, dev_dout_en is high and dev_dout equals the write data from the first STROBE clock to the last HOLD clock. Otherwise dev_dout_en is low and dev_dout is 0.
- R6: Busy stays high for max(hold, recovery)+1 clocks after the strobe is released. Clocks beyond the hold window (RECOVER) have chip selects and address inactive.
- R7: A read samples dev_din on the last STROBE clock. The value appears on rsp_rdata from the next clock and holds until the next read completes. Writes leave rsp_rdata unchanged.
- R8: rsp_ack is high for exactly one clock per access: the first clock after the last busy clock.
- R9: With req_stretch=1, each clock on which the twice-registered dev_ready is low keeps STROBE from advancing. With req_stretch=0, dev_ready has no effect.
- R10: Timing counts of 0 give one-clock phases, so the shortest access keeps busy high for 3 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs1 | input | 1 | 1 = assert dev_cs1_n, 0 = assert dev_cs0_n |
| req_addr | input | 3 | Device register address |
| req_wdata | input | 16 | Write data |
| req_t_setup | input | 8 | Setup count |
| req_t_strobe | input | 8 | Strobe count |
| req_t_hold | input | 8 | Hold count |
| req_t_recov | input | 8 | Recovery count |
| req_stretch | input | 1 | Allow dev_ready to stretch the strobe |
| dev_ready | input | 1 | Asynchronous device ready line |
| dev_din | input | 16 | Data bus from the device |
| dev_cs0_n | output | 1 | Chip select 0, active low |
| dev_cs1_n | output | 1 | Chip select 1, active low |
| dev_addr | output | 3 | Device address lines |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_dout | output | 16 | Data bus toward the device |
| dev_dout_en | output | 1 | Data bus driver enable |
| busy | output | 1 | Access in progress |
| rsp_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Captured read data |

## Verification
A wrong state or a miscounted phase shows on the chip selects and strobes in the very clock where it happens. The bench's cycle-level model catches it at once, as a strobe that is one clock long or short, or a chip select that drops early. A wrong capture point appears as a wrong rsp_rdata on the clock after the strobe ends, because the bench changes dev_din every clock. A faulty stretch path shows as a strobe whose length does not follow the dev_ready pattern seen two clocks earlier.

// File: rtl/pio_cycle_pkg.sv
package pio_cycle_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOVER
    } pio_phase_e;

endpackage

// File: rtl/pio_sync2.sv
module pio_sync2 #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pio_down_cnt.sv
module pio_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
    import pio_cycle_pkg::*;
#(
    parameter int TIME_W = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_cs1,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TIME_W-1:0] req_t_setup,
    input  logic [TIME_W-1:0] req_t_strobe,
    input  logic [TIME_W-1:0] req_t_hold,
    input  logic [TIME_W-1:0] req_t_recov,
    input  logic              req_stretch,
    input  logic              dev_ready,
    input  logic [DATA_W-1:0] dev_din,
    output logic              dev_cs0_n,
    output logic              dev_cs1_n,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              dev_rd_n,
    output logic              dev_wr_n,
    output logic [DATA_W-1:0] dev_dout,
    output logic              dev_dout_en,
    output logic              busy,
    output logic              rsp_ack,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int NUM_CNT = 2;
    localparam int CNT_PH  = 0;
    localparam int CNT_REC = 1;

    pio_phase_e st, st_nx;

    // latched request
    logic              wr_q, cs1_q, stretch_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [TIME_W-1:0] t_strobe_q, t_hold_q, t_recov_q;

    // counter controls
    logic [NUM_CNT-1:0]             c_load, c_dec, c_zero;
    logic [NUM_CNT-1:0][TIME_W-1:0] c_val;

    logic rdy_sync, stall, accept, capture;
    logic drive_sel, strobe_on;

    pio_sync2 #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_rdy_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (dev_ready),
        .q    (rdy_sync)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        pio_down_cnt #(.W(TIME_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (c_load[g]),
            .load_val(c_val[g]),
            .dec     (c_dec[g]),
            .zero    (c_zero[g])
        );
    end

    assign stall = stretch_q && !rdy_sync;

    // next state and counter control
    always_comb begin
        st_nx   = st;
        c_load  = '0;
        c_dec   = '0;
        c_val   = '0;
        accept  = 1'b0;
        capture = 1'b0;
        unique case (st)
            PH_IDLE: begin
                if (req_valid) begin
                    accept         = 1'b1;
                    c_load[CNT_PH] = 1'b1;
                    c_val[CNT_PH]  = req_t_setup;
                    st_nx          = PH_SETUP;
                end
            end
            PH_SETUP: begin
                if (c_zero[CNT_PH]) begin
                    c_load[CNT_PH] = 1'b1;
                    c_val[CNT_PH]  = t_strobe_q;
                    st_nx          = PH_STROBE;
                end else begin
                    c_dec[CNT_PH] = 1'b1;
                end
            end
            PH_STROBE: begin
                if (!stall) begin
                    if (c_zero[CNT_PH]) begin
                        capture         = !wr_q;
                        c_load[CNT_PH]  = 1'b1;
                        c_val[CNT_PH]   = t_hold_q;
                        c_load[CNT_REC] = 1'b1;
                        c_val[CNT_REC]  = t_recov_q;
                        st_nx           = PH_HOLD;
                    end else begin
                        c_dec[CNT_PH] = 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                c_dec[CNT_REC] = 1'b1;
                if (c_zero[CNT_PH]) begin
                    st_nx = c_zero[CNT_REC] ? PH_IDLE : PH_RECOVER;
                end else begin
                    c_dec[CNT_PH] = 1'b1;
                end
            end
            PH_RECOVER: begin
                if (c_zero[CNT_REC]) begin
                    st_nx = PH_IDLE;
                end else begin
                    c_dec[CNT_REC] = 1'b1;
                end
            end
            default: st_nx = PH_IDLE;
        endcase
    end

    // state register, request latch, response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= PH_IDLE;
            wr_q       <= 1'b0;
            cs1_q      <= 1'b0;
            stretch_q  <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
            t_strobe_q <= '0;
            t_hold_q   <= '0;
            t_recov_q  <= '0;
            rsp_ack    <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            st      <= st_nx;
            rsp_ack <= (st != PH_IDLE) && (st_nx == PH_IDLE);
            if (accept) begin
                wr_q       <= req_write;
                cs1_q      <= req_cs1;
                stretch_q  <= req_stretch;
                addr_q     <= req_addr;
                wdata_q    <= req_wdata;
                t_strobe_q <= req_t_strobe;
                t_hold_q   <= req_t_hold;
                t_recov_q  <= req_t_recov;
            end
            if (capture) begin
                rsp_rdata <= dev_din;
            end
        end
    end

    // output decode
    always_comb begin
        drive_sel = 1'b0;
        strobe_on = 1'b0;
        unique case (st)
            PH_IDLE:    ;
            PH_SETUP:   drive_sel = 1'b1;
            PH_STROBE: begin
                drive_sel = 1'b1;
                strobe_on = 1'b1;
            end
            PH_HOLD:    drive_sel = 1'b1;
            PH_RECOVER: ;
            default:    ;
        endcase
        busy        = (st != PH_IDLE);
        dev_cs0_n   = !(drive_sel && !cs1_q);
        dev_cs1_n   = !(drive_sel && cs1_q);
        dev_addr    = drive_sel ? addr_q : '0;
        dev_rd_n    = !(strobe_on && !wr_q);
        dev_wr_n    = !(strobe_on && wr_q);
        dev_dout_en = wr_q && (st == PH_STROBE || st == PH_HOLD);
        dev_dout    = dev_dout_en ? wdata_q : '0;
    end
endmodule

// File: rtl/pio_cycle_engine_chk.sv
module pio_cycle_engine_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              dev_cs0_n,
    input logic              dev_cs1_n,
    input logic              dev_rd_n,
    input logic              dev_wr_n,
    input logic [DATA_W-1:0] dev_dout,
    input logic              dev_dout_en,
    input logic              busy,
    input logic              rsp_ack
);
    AST_CS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_cs0_n && !dev_cs1_n)); // R3
    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rd_n || !dev_wr_n) |-> (!dev_cs0_n || !dev_cs1_n)); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_rd_n && !dev_wr_n)); // R4
    AST_DRIVE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dev_dout_en |-> dev_rd_n); // R5
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_dout_en && $past(dev_dout_en)) |-> $stable(dev_dout)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dev_cs0_n && dev_cs1_n && dev_rd_n && dev_wr_n && !dev_dout_en)); // R2
    AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid)); // R2
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |=> !rsp_ack); // R8
    AST_ACK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |-> (!busy && $past(busy))); // R8
endmodule

bind pio_cycle_engine pio_cycle_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .dev_cs0_n  (dev_cs0_n),
    .dev_cs1_n  (dev_cs1_n),
    .dev_rd_n   (dev_rd_n),
    .dev_wr_n   (dev_wr_n),
    .dev_dout   (dev_dout),
    .dev_dout_en(dev_dout_en),
    .busy       (busy),
    .rsp_ack    (rsp_ack)
);

// File: tb/pio_cycle_engine_tb_top.sv
`timescale 1ns/1ps
module pio_cycle_engine_tb_top;
    localparam int M_IDLE = 0, M_SETUP = 1, M_STROBE = 2, M_HOLD = 3, M_RECOV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_cs1 = 1'b0, req_stretch = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [7:0]  req_t_setup = '0, req_t_strobe = '0, req_t_hold = '0, req_t_recov = '0;
    logic        dev_ready = 1'b1;
    logic [15:0] dev_din = '0;
    logic        dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n, dev_dout_en, busy, rsp_ack;
    logic [2:0]  dev_addr;
    logic [15:0] dev_dout, rsp_rdata;

    int n_cmp = 0, n_bad = 0, cyc = 0;

    always #2 clk = ~clk;

    pio_cycle_engine dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cs1(req_cs1), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_t_setup(req_t_setup), .req_t_strobe(req_t_strobe),
        .req_t_hold(req_t_hold), .req_t_recov(req_t_recov),
        .req_stretch(req_stretch), .dev_ready(dev_ready), .dev_din(dev_din),
        .dev_cs0_n(dev_cs0_n), .dev_cs1_n(dev_cs1_n), .dev_addr(dev_addr),
        .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_dout(dev_dout),
        .dev_dout_en(dev_dout_en), .busy(busy), .rsp_ack(rsp_ack),
        .rsp_rdata(rsp_rdata)
    );

    // ---------------- reference model ----------------
    int          cur = M_IDLE;
    int          plan[$];
    bit          m_wr, m_cs1, m_stretch, s1 = 1'b1, s2 = 1'b1, e_ack = 1'b0;
    logic [2:0]  m_addr;
    logic [15:0] m_wdata, e_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            cur = M_IDLE; plan.delete(); s1 = 1'b1; s2 = 1'b1;
            e_ack = 1'b0; e_rdata = '0;
        end else begin
            e_ack = 1'b0;
            if (cur == M_IDLE) begin
                if (req_valid) begin
                    m_wr = req_write; m_cs1 = req_cs1; m_stretch = req_stretch;
                    m_addr = req_addr; m_wdata = req_wdata;
                    for (int i = 0; i <= int'(req_t_setup); i++) plan.push_back(M_SETUP);
                    for (int i = 0; i <= int'(req_t_strobe); i++) plan.push_back(M_STROBE);
                    for (int i = 0; i <= int'(req_t_hold); i++) plan.push_back(M_HOLD);
                    for (int i = 0; i < int'(req_t_recov) - int'(req_t_hold); i++) plan.push_back(M_RECOV);
                    cur = plan.pop_front();
                end
            end else if (cur == M_STROBE && m_stretch && !s2) begin
                cur = M_STROBE;
            end else if (plan.size() == 0) begin
                cur = M_IDLE; e_ack = 1'b1;
            end else begin
                int nx;
                nx = plan.pop_front();
                if (cur == M_STROBE && nx != M_STROBE && !m_wr) e_rdata = dev_din;
                cur = nx;
            end
            s2 = s1; s1 = dev_ready;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            bit drv;
            bit e_cs0, e_cs1, e_rd, e_wr, e_en;
            logic [2:0] e_ad;
            logic [15:0] e_do;
            drv   = (cur == M_SETUP) || (cur == M_STROBE) || (cur == M_HOLD);
            e_cs0 = !(drv && !m_cs1);
            e_cs1 = !(drv && m_cs1);
            e_ad  = drv ? m_addr : 3'd0;
            e_rd  = !(cur == M_STROBE && !m_wr);
            e_wr  = !(cur == M_STROBE && m_wr);
            e_en  = m_wr && (cur == M_STROBE || cur == M_HOLD);
            e_do  = e_en ? m_wdata : 16'd0;
            chk(busy == (cur != M_IDLE), "R2/R6", "busy", busy, cur != M_IDLE);
            chk(dev_cs0_n == e_cs0, "R3", "cs0_n", dev_cs0_n, e_cs0);
            chk(dev_cs1_n == e_cs1, "R3", "cs1_n", dev_cs1_n, e_cs1);
            chk(dev_addr == e_ad, "R3", "addr", dev_addr, e_ad);
            chk(dev_rd_n == e_rd, "R4/R9", "rd_n", dev_rd_n, e_rd);
            chk(dev_wr_n == e_wr, "R4/R9", "wr_n", dev_wr_n, e_wr);
            chk(dev_dout_en == e_en, "R5", "dout_en", dev_dout_en, e_en);
            chk(dev_dout == e_do, "R5", "dout", dev_dout, e_do);
            chk(rsp_ack == e_ack, "R8", "ack", rsp_ack, e_ack);
            chk(rsp_rdata == e_rdata, "R7", "rdata", rsp_rdata, e_rdata);
        end
        dev_din <= dev_din + 16'h1357;
    end

    // ---------------- stimulus ----------------
    task automatic put_req(input bit wr, input bit cs1, input logic [2:0] ad,
                           input logic [15:0] wd, input int t1, input int t2,
                           input int t4, input int te, input bit st);
        req_valid = 1'b1; req_write = wr; req_cs1 = cs1; req_addr = ad;
        req_wdata = wd; req_t_setup = 8'(t1); req_t_strobe = 8'(t2);
        req_t_hold = 8'(t4); req_t_recov = 8'(te); req_stretch = st;
    endtask

    task automatic wait_ack();
        int guard = 0;
        while (rsp_ack !== 1'b1 && guard < 2000) begin
            @(negedge clk); guard++;
        end
        @(negedge clk);
    endtask

    task automatic run(input bit wr, input bit cs1, input logic [2:0] ad,
                       input logic [15:0] wd, input int t1, input int t2,
                       input int t4, input int te, input bit st);
        @(negedge clk);
        put_req(wr, cs1, ad, wd, t1, t2, t4, te, st);
        @(negedge clk);
        req_valid = 1'b0;
        wait_ack();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0 && rsp_ack == 1'b0 && dev_dout_en == 1'b0, "R1", "busy/ack/en", {busy, rsp_ack, dev_dout_en}, 0);
        chk(dev_cs0_n && dev_cs1_n && dev_rd_n && dev_wr_n, "R1", "cs/strobes", {dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n}, 4'hf);
        chk(rsp_rdata == 16'd0 && dev_addr == 3'd0, "R1", "rdata/addr", rsp_rdata, 0);
        @(negedge clk); rst_n = 1'b1;

        // R3 R4 R7: read through chip select 0
        run(1'b0, 1'b0, 3'd3, 16'h0, 2, 3, 1, 4, 1'b0);
        // R5 R6: write through chip select 1, hold longer than recovery
        run(1'b1, 1'b1, 3'd5, 16'hA5C3, 1, 2, 5, 2, 1'b0);
        // R6: recovery much longer than hold
        run(1'b1, 1'b0, 3'd7, 16'h1234, 0, 1, 0, 9, 1'b0);
        // R10: all-zero counts, read then write
        run(1'b0, 1'b1, 3'd1, 16'h0, 0, 0, 0, 0, 1'b0);
        run(1'b1, 1'b1, 3'd2, 16'hFFFF, 0, 0, 0, 0, 1'b0);
        // R10: explicit minimum busy length
        begin
            int nb = 0;
            @(negedge clk);
            put_req(1'b0, 1'b0, 3'd4, 16'h0, 0, 0, 0, 0, 1'b0);
            @(negedge clk); req_valid = 1'b0;
            while (busy) begin nb++; @(negedge clk); end
            chk(nb == 3, "R10", "busy clocks", nb, 3);
            @(negedge clk);
        end

        // R9: stretched read, dev_ready low during the strobe
        @(negedge clk);
        put_req(1'b0, 1'b0, 3'd6, 16'h0, 1, 2, 1, 3, 1'b1);
        @(negedge clk); req_valid = 1'b0;
        repeat (2) @(negedge clk);
        dev_ready = 1'b0;
        repeat (6) @(negedge clk);
        dev_ready = 1'b1;
        wait_ack();

        // R9: stretch disabled, dev_ready low has no effect
        @(negedge clk);
        dev_ready = 1'b0;
        put_req(1'b1, 1'b0, 3'd2, 16'hBEEF, 1, 3, 1, 1, 1'b0);
        @(negedge clk); req_valid = 1'b0;
        wait_ack();
        dev_ready = 1'b1;

        // R2: request pulse during a busy cycle is ignored
        @(negedge clk);
        put_req(1'b0, 1'b1, 3'd3, 16'h0, 3, 4, 1, 5, 1'b0);
        @(negedge clk); req_valid = 1'b0;
        repeat (4) @(negedge clk);
        put_req(1'b1, 1'b0, 3'd7, 16'h7777, 0, 0, 0, 0, 1'b0);
        @(negedge clk); req_valid = 1'b0;
        wait_ack();
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R2", "ignored request started", busy, 0);

        // R2 R8: back-to-back, request held across the ack clock
        @(negedge clk);
        put_req(1'b0, 1'b0, 3'd1, 16'h0, 1, 1, 0, 1, 1'b0);
        @(negedge clk);
        put_req(1'b1, 1'b1, 3'd4, 16'h5A5A, 1, 1, 1, 1, 1'b0);
        while (rsp_ack !== 1'b1) @(negedge clk);
        @(negedge clk); req_valid = 1'b0;
        wait_ack();

        // R4 R6: mode-0 style counts
        run(1'b0, 1'b0, 3'd0, 16'h0, 6, 28, 2, 23, 1'b0);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule